// File: doc/BRIEF.md
# Byte/Word Switchable Parallel Memory Bus Front End

This block is the device side of a parallel nonvolatile memory bus. Once per clock it samples four active-low controls (chip enable, output enable, write enable, hardware reset) and decodes them into a read, a write, standby, output-disable or reset. A behavioural storage array, filled with a fixed pattern while reset is held, stands in for the real cells. Reads need no prior command: the block is in read-array mode from reset onwards.

A run-time width select sets the bus width. When it is high, all sixteen data pins carry a word. When it is low, only the lower eight pins carry data, pins 8 to 14 float, and pin 15 becomes an input that gives the least-significant byte address bit. The same array can then be read either as words or as bytes. A write cycle's address and data are captured into a command register, which is not part of the readable address space. The capture is announced by a one-cycle strobe so that a command interpreter further down can take it. The data pins are modelled as separate input, output and per-bit output-enable vectors.

Top module: `flash_bus_front`

## Requirements
- R1: In word mode (`word_sel`=1), if a clock edge samples `ce_n`=0, `oe_n`=0, `we_n`=1, then after that edge `dq_oe`=16'hFFFF and `dq_out` holds the array word at `addr`.
- R2: In byte mode (`word_sel`=0), a read cycle gives `dq_oe`=16'h00FF and `dq_out[15:8]`=0. `dq_out[7:0]` is the low byte of the addressed word when `dq_in[15]`=0 and the high byte when it is 1.
- R3: An edge that samples `ce_n`=1 leaves `dq_oe`=0 and `dq_out`=0, whatever the other controls are.
- R4: An edge that samples `ce_n`=0 with `oe_n`=1 leaves `dq_oe`=0 and `dq_out`=0.
- R5: While `rst_n`=0, `dq_oe`, `dq_out`, `cmd_valid`, `cmd_addr` and `cmd_data` are all zero, without waiting for a clock edge. The first edge after release can already perform a read.
- R6: After reset, array word i holds (i*40503+4660) mod 65536 for i in 0..2^ARRAY_AW-1. Address bits at and above ARRAY_AW are ignored, so higher addresses alias.
- R7: The strobe fires when an edge samples `ce_n`=0, `we_n`=0, `oe_n`=1 and the next edge samples `we_n`=1 with `ce_n`=0. After that second edge, `cmd_valid` is 1 for exactly one cycle. `cmd_addr` becomes the byte address {`addr`, b}, where b is 0 in word mode and `dq_in[15]` in byte mode. `cmd_data` becomes `dq_in` in word mode and {8'h00, `dq_in[7:0]`} in byte mode, all taken from the second edge.
- R8: `cmd_addr` and `cmd_data` do not change between strobes. Writes never change array contents as seen by later reads.
- R9: An edge that samples `ce_n`, `oe_n` and `we_n` all low drives nothing. A later rise of `we_n` from that state produces no strobe.
- R10: When write enable rises on the same edge that output enable falls (with `ce_n`=0), the strobe of R7 and the read of R1/R2 both take effect after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| word_sel | input | 1 | 1 = word mode, 0 = byte mode |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data pins as seen from outside; bit 15 is the byte address bit in byte mode |
| dq_out | output | 16 | Data driven onto the pins |
| dq_oe | output | 16 | Per-pin output enable |
| cmd_valid | output | 1 | One-cycle strobe for a captured write |
| cmd_addr | output | ADDR_W+1 | Captured byte address |
| cmd_data | output | 16 | Captured write data |

## Verification
A write strobe and a read can occur in the same cycle. This happens when write enable returns high on the same edge that output enable goes low, so the closing write cycle and the opening read share one sample. The bench drives this overlap in both bus widths, both on purpose and through random control patterns. Every cycle, a behavioural model checks that the strobe carries the pins from the closing edge while the data pins carry the array value.

// File: rtl/flash_bus_front.sv
module flash_bus_front #(
  parameter int ADDR_W   = 20,
  parameter int ARRAY_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              word_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [15:0]       dq_oe,
  output logic              cmd_valid,
  output logic [ADDR_W:0]   cmd_addr,
  output logic [15:0]       cmd_data
);
  localparam int DEPTH = 1 << ARRAY_AW;

  logic [15:0] mem [DEPTH];
  logic        wr_q;

  wire         rd_cyc  = ~ce_n & ~oe_n & we_n;
  wire         wr_cyc  = ~ce_n & ~we_n & oe_n;
  wire         wr_done = wr_q & ~ce_n & we_n;
  wire         lsb     = dq_in[15];
  wire  [15:0] word    = mem[addr[ARRAY_AW-1:0]];
  wire  [7:0]  byte_v  = lsb ? word[15:8] : word[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 16'(i * 40503 + 4660);
      wr_q      <= 1'b0;
      dq_oe     <= '0;
      dq_out    <= '0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      wr_q      <= wr_cyc;
      cmd_valid <= wr_done;
      if (wr_done) begin
        cmd_addr <= word_sel ? {addr, 1'b0} : {addr, lsb};
        cmd_data <= word_sel ? dq_in : {8'h00, dq_in[7:0]};
      end
      if (rd_cyc) begin
        dq_oe  <= word_sel ? 16'hFFFF : 16'h00FF;
        dq_out <= word_sel ? word : {8'h00, byte_v};
      end else begin
        dq_oe  <= '0;
        dq_out <= '0;
      end
    end
  end

  p_standby_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n) |-> dq_oe == '0);
  p_outdis_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ce_n && oe_n) |-> dq_oe == '0);
  p_drive_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != '0) |-> $past(!ce_n && !oe_n && we_n));
  p_byte_float_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!word_sel) |-> dq_oe[15:8] == 8'h00);
  p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_cmd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> ($stable(cmd_addr) && $stable(cmd_data)));
  p_conflict_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ce_n && !oe_n && !we_n) |-> dq_oe == '0);
endmodule

// File: tb/flash_bus_front_test.sv
`timescale 1ns/1ps
module flash_bus_front_test;
  localparam int AW = 20;
  localparam int MAW = 10;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, word_sel = 1;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, dq_oe, cmd_data;
  logic cmd_valid;
  logic [AW:0] cmd_addr;

  int checks = 0, errors = 0;

  flash_bus_front #(.ADDR_W(AW), .ARRAY_AW(MAW)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .word_sel(word_sel), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data));

  always #2.5 clk = ~clk;

  function automatic logic [15:0] arr(int a);
    return 16'(((a % (1 << MAW)) * 40503 + 4660) & 16'hFFFF);
  endfunction

  task automatic chk(string r, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", r, got, exp, $time);
    end
  endtask

  // behavioural reference, updated on every edge
  logic [15:0] e_oe, e_out, e_cd;
  logic [AW:0] e_ca;
  logic e_cv, prev_wr;
  string e_tag;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_oe <= 0; e_out <= 0; e_cv <= 0; e_ca <= 0; e_cd <= 0; prev_wr <= 0; e_tag <= "R5";
    end else begin
      logic [15:0] w;
      w = arr(int'(addr));
      if (!ce_n && !oe_n && we_n) begin
        if (word_sel) begin e_oe <= 16'hFFFF; e_out <= w; e_tag <= "R1"; end
        else begin
          e_oe <= 16'h00FF; e_tag <= "R2";
          e_out <= dq_in[15] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
        end
      end else begin
        e_oe <= 0; e_out <= 0;
        e_tag <= ce_n ? "R3" : (oe_n ? "R4" : "R9");
      end
      e_cv <= prev_wr && !ce_n && we_n;
      if (prev_wr && !ce_n && we_n) begin
        e_ca <= word_sel ? {addr, 1'b0} : {addr, dq_in[15]};
        e_cd <= word_sel ? dq_in : {8'h00, dq_in[7:0]};
      end
      prev_wr <= !ce_n && !we_n && oe_n;
    end
  end

  always @(negedge clk) begin
    chk({e_tag, " dq_oe"}, 32'(dq_oe), 32'(e_oe));
    chk({e_tag, " dq_out"}, 32'(dq_out), 32'(e_out));
    chk("R7 cmd_valid", 32'(cmd_valid), 32'(e_cv));
    chk("R7/R8 cmd_addr", 32'(cmd_addr), 32'(e_ca));
    chk("R7/R8 cmd_data", 32'(cmd_data), 32'(e_cd));
  end

  task automatic step(logic c, logic o, logic w, logic ws, int a, logic [15:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; word_sel = ws; addr = AW'(a); dq_in = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w, lo, hi;
    step(0, 0, 1, 1, 3, 0);
    repeat (2) @(negedge clk);
    chk("R5 reset dq_oe", 32'(dq_oe), 0);
    chk("R5 reset cmd_valid", 32'(cmd_valid), 0);
    rst_n = 1;
    // R1 and R6: word reads incl. ends and aliasing
    step(0, 0, 1, 1, 0, 0);
    step(0, 0, 1, 1, 1023, 0);
    step(0, 0, 1, 1, 1024 + 5, 0);
    step(0, 0, 1, 1, 5, 0);
    @(negedge clk);
    chk("R6 alias word 5", 32'(dq_out), 32'(arr(5)));
    // R2: byte reads reassemble the word
    step(0, 0, 1, 1, 77, 0);
    step(0, 0, 1, 0, 77, 16'h0000);
    w = dq_out;
    step(0, 0, 1, 0, 77, 16'h8000);
    lo = dq_out;
    step(1, 1, 1, 1, 0, 0);
    hi = dq_out;
    chk("R2 bytes match word", 32'({hi[7:0], lo[7:0]}), 32'(w));
    // R3 / R4
    step(1, 0, 1, 1, 9, 0);
    step(1, 0, 0, 0, 9, 0);
    step(0, 1, 1, 1, 9, 0);
    // R7 word write
    step(0, 1, 0, 1, 300, 16'hBEEF);
    step(0, 1, 1, 1, 300, 16'hBEEF);
    @(negedge clk);
    chk("R7 word cmd_addr", 32'(cmd_addr), 32'(600));
    // R7 byte write
    step(0, 1, 0, 0, 12, 16'h80C3);
    step(0, 1, 1, 0, 12, 16'h80C3);
    step(1, 1, 1, 1, 0, 0);
    chk("R7 byte cmd_data", 32'(cmd_data), 32'h00C3);
    // R8: hold and array unchanged
    repeat (3) step(0, 0, 1, 1, 300, 0);
    chk("R8 array unchanged", 32'(dq_out), 32'(arr(300)));
    chk("R8 cmd held", 32'(cmd_data), 32'h00C3);
    // R9: all low, then we rises
    step(0, 0, 0, 1, 40, 16'h1111);
    step(0, 0, 1, 1, 40, 16'h1111);
    step(0, 0, 1, 1, 40, 16'h1111);
    chk("R9 no strobe", 32'(cmd_valid), 0);
    // R10: we rises as oe falls, both widths
    step(0, 1, 0, 1, 50, 16'h2222);
    step(0, 0, 1, 1, 51, 16'h3333);
    step(0, 1, 0, 0, 60, 16'h4444);
    step(0, 0, 1, 0, 61, 16'h8055);
    step(1, 1, 1, 1, 0, 0);
    chk("R10 strobe with read", 32'(cmd_addr), 32'(123));
    // random patterns
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[2], r[3], r[4], int'(r[31:12]), r[27:12]);
    end
    // R5: asynchronous reset mid-run
    step(0, 1, 0, 1, 7, 16'h1234);
    step(0, 1, 1, 1, 7, 16'h1234);
    @(negedge clk);
    #1 rst_n = 0;
    #1 chk("R5 async cmd_addr", 32'(cmd_addr), 0);
    chk("R5 async dq_oe", 32'(dq_oe), 0);
    @(negedge clk);
    rst_n = 1;
    step(0, 0, 1, 1, 7, 0);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule